// File: doc/BRIEF.md
# PUF Key Reconstruction Controller

This block turns a noisy challenge-driven response into a stable 128-bit key. A 16-bit challenge seeds a linear feedback shift register that stands in for the physical response source. A test input can flip any response bits to model noise. The 128 response bits are cut into nineteen 7-bit segments, and the last segment is padded with zeros. Each segment is one message of a systematic double-error-correcting BCH code of length 15.

There are two operations. Enrollment produces the response and 8 parity bits per segment, called the helper data. It also stores the challenge and the helper data in a small table under a key handle. Reconstruction regenerates the response from a challenge and its helper data, taken either from the ports or from the table by handle. It then corrects up to two flipped bits in every segment and presents the corrected key.

Operations start with a one-cycle `start` pulse. The block then takes one cycle per segment, raises `busy` while it runs, and gives a one-cycle `done` at the end.

Top module: `puf_keyrec`

## Requirements
- R1: Segment k (k = 0..18) takes response bits 7k..7k+6, and bit 7k+b is the coefficient of x^b. Bits at positions 128 and above are zero. The helper field `helper_out[8k+7:8k]` holds the remainder of (segment · x^8) divided by g(x) = x^8+x^7+x^6+x^4+1, with bit i as the coefficient of x^i.
- R2: Response bit n is the n-th output of a 16-bit shift register seeded with the challenge, or with 16'h0001 when the challenge is zero. Each step outputs bit 15, then shifts left and inserts bit15^bit13^bit12^bit10 at bit 0.
- R3: Enrollment (`op_enroll`=1) ends with `key_out` equal to the response XOR `noise_in`, `key_valid`=1, and the helper computed from that noisy response.
- R4: Explicit reconstruction (`op_enroll`=0, `op_by_handle`=0) uses `chal_in` and `helper_in`. When every segment carries at most two flipped bits, it returns the enrollment response with `key_valid`=1 and `uncorr_err`=0.
- R5: A segment whose syndrome matches no error pattern of weight two or less sets `uncorr_err`. The flag stays set to the end of the operation, and `key_valid` stays 0.
- R6: Enrollment stores the challenge and helper under `handle_in`. A later reconstruction with `op_by_handle`=1 and that handle uses the stored pair and reports the stored challenge on `chal_out`.
- R7: Reconstruction by a handle that was never enrolled ends at once with `done`=1, `handle_err`=1, `key_valid`=0 and `key_out` all zero.
- R8: In enrollment, `chal_from_rng`=1 takes the challenge from `rng_in` and 0 takes it from `chal_in`. `chal_out` reports the challenge that was used.
- R9: An accepted `start` clears `key_out`, `key_valid`, `uncorr_err` and `handle_err` on the next cycle and raises `busy`. `done` is high for one cycle only. A `start` given while busy has no effect.
- R10: After reset, `busy`, `done`, `key_valid`, `uncorr_err` and `handle_err` are 0, `key_out` is zero, and no handle is enrolled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_enroll | input | 1 | 1 = enrollment, 0 = reconstruction |
| op_by_handle | input | 1 | Reconstruction takes challenge/helper from the table |
| chal_from_rng | input | 1 | Enrollment challenge from `rng_in` |
| chal_in | input | 16 | Explicit challenge |
| rng_in | input | 16 | Random challenge source |
| handle_in | input | 3 | Key handle for storing or lookup |
| helper_in | input | 152 | Explicit helper data |
| noise_in | input | 128 | Test bit flips applied to the raw response |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| key_out | output | 128 | Response / corrected key |
| key_valid | output | 1 | Key is good |
| helper_out | output | 152 | Helper data of the last operation |
| chal_out | output | 16 | Challenge used by the last operation |
| uncorr_err | output | 1 | Some segment was uncorrectable |
| handle_err | output | 1 | Lookup of an empty handle |

## Verification
Enrollment runs over several challenges, including zero, all ones and an RNG-sourced value. This separates the seed rule, the bit order of the response and the parity layout. Reconstruction then runs with zero, one, two and three flipped bits per segment. The first three must correct cleanly. Three flips show whether the decoder miscorrects or flags the segment, judged against an exhaustive weight-two search in the bench. A three-bit pattern chosen to be undecodable confirms the sticky flag. An enrollment under noise followed by a clean lookup shows that correction converges on the enrolled response and not on the clean one.

// File: rtl/puf_keyrec_pkg.sv
package puf_keyrec_pkg;
  localparam int SEG_D = 7;
  localparam int SEG_P = 8;
  localparam int CW_W  = SEG_D + SEG_P;
  localparam logic [SEG_P:0] GEN_POLY = 9'h1D1;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_st_e;

  // remainder of a 15-bit codeword polynomial modulo the generator
  function automatic logic [SEG_P-1:0] bch_rem(input logic [CW_W-1:0] cw);
    logic [CW_W-1:0] r;
    r = cw;
    for (int k = CW_W - 1; k >= SEG_P; k--) begin
      if (r[k]) r = r ^ (CW_W'(GEN_POLY) << (k - SEG_P));
    end
    return r[SEG_P-1:0];
  endfunction

  // syndrome of a single flipped bit at position i
  function automatic logic [SEG_P-1:0] unit_syn(input int i);
    return bch_rem(CW_W'(1) << i);
  endfunction
endpackage

// File: rtl/puf_lfsr_src.sv
module puf_lfsr_src #(
  parameter int W = 16,
  parameter int STEP = 7,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [W-1:0]    seed,
  output logic [STEP-1:0] bits
);
  logic [W-1:0] state_q, state_d, walk;

  always_comb begin
    walk = state_q;
    for (int b = 0; b < STEP; b++) begin
      bits[b] = walk[W-1];
      walk = {walk[W-2:0], ^(walk & TAPS)};
    end
    state_d = state_q;
    if (load)      state_d = (seed == '0) ? W'(1) : seed;
    else if (step) state_d = walk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              state_q <= W'(1);
    else if (load || step)   state_q <= state_d;
  end

  p_state_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/bch_seg_codec.sv
module bch_seg_codec
  import puf_keyrec_pkg::*;
(
  input  logic [SEG_D-1:0] data,
  input  logic [SEG_P-1:0] par_in,
  output logic [SEG_P-1:0] par_out,
  output logic [CW_W-1:0]  cw_fix,
  output logic             bad
);
  logic [CW_W-1:0]            cw, err;
  logic [SEG_P-1:0]           syn;
  logic [CW_W-1:0]            one_hit;
  logic [CW_W-1:0][CW_W-1:0]  pair_hit;

  assign par_out = bch_rem({data, {SEG_P{1'b0}}});
  assign cw      = {data, par_in};
  assign syn     = bch_rem(cw);

  for (genvar gi = 0; gi < CW_W; gi++) begin : g_row
    localparam logic [SEG_P-1:0] SI = unit_syn(gi);
    assign one_hit[gi] = (syn == SI);
    for (genvar gj = 0; gj < CW_W; gj++) begin : g_col
      if (gj > gi) begin : g_pair
        localparam logic [SEG_P-1:0] SJ = unit_syn(gj);
        assign pair_hit[gi][gj] = (syn == (SI ^ SJ));
      end else begin : g_none
        assign pair_hit[gi][gj] = 1'b0;
      end
    end
  end

  always_comb begin
    err = '0;
    for (int k = 0; k < CW_W; k++) begin
      err[k] = one_hit[k];
      for (int m = 0; m < CW_W; m++) begin
        if (pair_hit[k][m] || pair_hit[m][k]) err[k] = 1'b1;
      end
    end
    bad    = (syn != '0) && !(|one_hit) && !(|pair_hit);
    cw_fix = cw ^ err;
  end
endmodule

// File: rtl/puf_handle_table.sv
module puf_handle_table #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int CW = 16,
  parameter int HW = 152
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [CW-1:0] wr_chal,
  input  logic [HW-1:0] wr_help,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [CW-1:0] rd_chal,
  output logic [HW-1:0] rd_help
);
  logic [N-1:0]  vld_vec;
  logic [CW-1:0] chal_arr [N];
  logic [HW-1:0] help_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic          vld_q;
    logic [CW-1:0] chal_q;
    logic [HW-1:0] help_q;
    logic          hit;
    assign hit = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q <= 1'b0;
      else if (hit) vld_q <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (hit) begin
        chal_q <= wr_chal;
        help_q <= wr_help;
      end
    end
    assign vld_vec[g]  = vld_q;
    assign chal_arr[g] = chal_q;
    assign help_arr[g] = help_q;
  end

  assign rd_valid = vld_vec[rd_idx];
  assign rd_chal  = chal_arr[rd_idx];
  assign rd_help  = help_arr[rd_idx];

  p_wr_sets_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_vec[$past(wr_idx)]);
endmodule

// File: rtl/puf_keyrec.sv
module puf_keyrec
  import puf_keyrec_pkg::*;
#(
  parameter int CHAL_W = 16,
  parameter int RESP_W = 128,
  parameter int N_KEYS = 8,
  parameter logic [CHAL_W-1:0] LFSR_TAPS = 16'hB400,
  localparam int NSEG   = (RESP_W + SEG_D - 1) / SEG_D,
  localparam int HELP_W = NSEG * SEG_P,
  localparam int HID_W  = $clog2(N_KEYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_enroll,
  input  logic              op_by_handle,
  input  logic              chal_from_rng,
  input  logic [CHAL_W-1:0] chal_in,
  input  logic [CHAL_W-1:0] rng_in,
  input  logic [HID_W-1:0]  handle_in,
  input  logic [HELP_W-1:0] helper_in,
  input  logic [RESP_W-1:0] noise_in,
  output logic              busy,
  output logic              done,
  output logic [RESP_W-1:0] key_out,
  output logic              key_valid,
  output logic [HELP_W-1:0] helper_out,
  output logic [CHAL_W-1:0] chal_out,
  output logic              uncorr_err,
  output logic              handle_err
);
  localparam int SEG_IW = $clog2(NSEG);
  localparam logic [SEG_IW-1:0] LAST_SEG = SEG_IW'(NSEG - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  run_st_e           st_q, st_d;
  logic [SEG_IW-1:0] seg_q, seg_d;
  logic              enr_q, enr_d;
  logic [CHAL_W-1:0] chal_q, chal_d, chal_pick;
  logic [RESP_W-1:0] key_q, key_d;
  logic [HELP_W-1:0] help_q, help_d;
  logic              uncorr_q, uncorr_d, herr_q, herr_d;
  logic              valid_q, valid_d, done_q, done_d;
  logic [RESP_W-1:0] noise_q;
  logic [HID_W-1:0]  hdl_q;
  logic              cap, lfsr_load, lfsr_step, tbl_wr;
  logic [SEG_D-1:0]  raw7, seg_data, data_fix;
  logic [SEG_P-1:0]  seg_par_in, par_enc;
  logic [CW_W-1:0]   cw_fix;
  logic              seg_bad;
  logic              rd_valid;
  logic [CHAL_W-1:0] rd_chal;
  logic [HELP_W-1:0] rd_help;

  puf_lfsr_src #(.W(CHAL_W), .STEP(SEG_D), .TAPS(LFSR_TAPS)) u_src (
    .clk(clk), .rst_n(rst_ns), .load(lfsr_load), .step(lfsr_step),
    .seed(chal_pick), .bits(raw7));

  bch_seg_codec u_codec (
    .data(seg_data), .par_in(seg_par_in), .par_out(par_enc),
    .cw_fix(cw_fix), .bad(seg_bad));
  assign data_fix = cw_fix[CW_W-1:SEG_P];

  puf_handle_table #(.N(N_KEYS), .IW(HID_W), .CW(CHAL_W), .HW(HELP_W)) u_tbl (
    .clk(clk), .rst_n(rst_ns), .wr_en(tbl_wr), .wr_idx(hdl_q),
    .wr_chal(chal_q), .wr_help(help_d), .rd_idx(handle_in),
    .rd_valid(rd_valid), .rd_chal(rd_chal), .rd_help(rd_help));

  // current segment: noisy raw bits, zero beyond the response width
  always_comb begin
    int idx;
    for (int b = 0; b < SEG_D; b++) begin
      idx = int'(seg_q) * SEG_D + b;
      if (idx < RESP_W) seg_data[b] = raw7[b] ^ noise_q[idx];
      else              seg_data[b] = 1'b0;
    end
    seg_par_in = help_q[int'(seg_q) * SEG_P +: SEG_P];
  end

  assign chal_pick = op_enroll ? (chal_from_rng ? rng_in : chal_in)
                               : (op_by_handle ? rd_chal : chal_in);

  // next-state logic
  always_comb begin
    int idx;
    st_d = st_q;  seg_d = seg_q;  enr_d = enr_q;  chal_d = chal_q;
    key_d = key_q;  help_d = help_q;  uncorr_d = uncorr_q;  herr_d = herr_q;
    valid_d = valid_q;  done_d = 1'b0;
    cap = 1'b0;  lfsr_load = 1'b0;  lfsr_step = 1'b0;  tbl_wr = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          cap = 1'b1;  key_d = '0;  valid_d = 1'b0;
          uncorr_d = 1'b0;  herr_d = 1'b0;  seg_d = '0;  enr_d = op_enroll;
          help_d = op_enroll ? '0 : (op_by_handle ? rd_help : helper_in);
          if (!op_enroll && op_by_handle && !rd_valid) begin
            herr_d = 1'b1;  done_d = 1'b1;  chal_d = '0;
          end else begin
            chal_d = chal_pick;  lfsr_load = 1'b1;  st_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        lfsr_step = 1'b1;
        for (int b = 0; b < SEG_D; b++) begin
          idx = int'(seg_q) * SEG_D + b;
          if (idx < RESP_W) key_d[idx] = enr_q ? seg_data[b] : data_fix[b];
        end
        if (enr_q) help_d[int'(seg_q) * SEG_P +: SEG_P] = par_enc;
        else if (seg_bad) uncorr_d = 1'b1;
        if (seg_q == LAST_SEG) begin
          st_d = ST_IDLE;  done_d = 1'b1;  valid_d = !uncorr_d;  tbl_wr = enr_q;
        end else begin
          seg_d = seg_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q <= ST_IDLE;  seg_q <= '0;  enr_q <= 1'b0;  chal_q <= '0;
      key_q <= '0;  help_q <= '0;  uncorr_q <= 1'b0;  herr_q <= 1'b0;
      valid_q <= 1'b0;  done_q <= 1'b0;
    end else begin
      st_q <= st_d;  seg_q <= seg_d;  enr_q <= enr_d;  chal_q <= chal_d;
      key_q <= key_d;  help_q <= help_d;  uncorr_q <= uncorr_d;  herr_q <= herr_d;
      valid_q <= valid_d;  done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      noise_q <= noise_in;
      hdl_q   <= handle_in;
    end
  end

  assign busy       = (st_q == ST_RUN);
  assign done       = done_q;
  assign key_out    = key_q;
  assign key_valid  = valid_q;
  assign helper_out = help_q;
  assign chal_out   = chal_q;
  assign uncorr_err = uncorr_q;
  assign handle_err = herr_q;

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> !busy);
  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy && start) |=> $stable(chal_out));
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (start && !busy) |=> (!key_valid && !uncorr_err));
  p_valid_clean_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    key_valid |-> (!uncorr_err && !handle_err));
  p_herr_nokey_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    handle_err |-> (key_out == '0 && !key_valid && !busy));
  p_fix_clean_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy && !enr_q && !seg_bad) |-> (bch_rem(cw_fix) == '0));
endmodule

// File: tb/puf_keyrec_tb_top.sv
module puf_keyrec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_enroll = 1'b0, op_by_handle = 1'b0, chal_from_rng = 1'b0;
  logic [15:0]  chal_in = '0, rng_in = '0;
  logic [2:0]   handle_in = '0;
  logic [151:0] helper_in = '0;
  logic [127:0] noise_in = '0;
  logic busy, done, key_valid, uncorr_err, handle_err;
  logic [127:0] key_out;
  logic [151:0] helper_out;
  logic [15:0]  chal_out;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  puf_keyrec dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_enroll(op_enroll),
    .op_by_handle(op_by_handle), .chal_from_rng(chal_from_rng),
    .chal_in(chal_in), .rng_in(rng_in), .handle_in(handle_in),
    .helper_in(helper_in), .noise_in(noise_in), .busy(busy), .done(done),
    .key_out(key_out), .key_valid(key_valid), .helper_out(helper_out),
    .chal_out(chal_out), .uncorr_err(uncorr_err), .handle_err(handle_err));

  // ---- reference model written from the requirements ----
  function automatic logic [7:0] m_rem(input logic [14:0] cw);
    int v = int'(cw);
    for (int b = 14; b >= 8; b--)
      if (((v >> b) & 1) == 1) v = v ^ ('h1D1 << (b - 8));
    return v[7:0];
  endfunction

  function automatic logic [127:0] m_resp(input logic [15:0] c);
    logic [15:0] s = (c == 16'h0) ? 16'h0001 : c;
    logic [127:0] r;
    for (int n = 0; n < 128; n++) begin
      r[n] = s[15];
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    end
    return r;
  endfunction

  function automatic logic [6:0] m_seg(input logic [127:0] r, input int k);
    logic [6:0] d;
    for (int b = 0; b < 7; b++) d[b] = (7 * k + b < 128) ? r[7 * k + b] : 1'b0;
    return d;
  endfunction

  function automatic logic [151:0] m_help(input logic [127:0] r);
    logic [151:0] h;
    for (int k = 0; k < 19; k++) h[8 * k +: 8] = m_rem({m_seg(r, k), 8'h00});
    return h;
  endfunction

  // exhaustive search over error patterns of weight 0..2
  task automatic m_dec(input logic [6:0] d, input logic [7:0] p,
                       output logic [6:0] fix, output logic bad);
    logic [14:0] e;
    bad = 1'b1;  fix = d;
    for (int i = 0; i < 16; i++)
      for (int j = i; j < 16; j++) begin
        e = '0;
        if (i < 15) e[i] = 1'b1;
        if (j < 15) e[j] = 1'b1;
        if (bad && m_rem({d, p} ^ e) == 8'h00) begin
          bad = 1'b0;  fix = d ^ e[14:8];
        end
      end
  endtask

  task automatic m_recon(input logic [127:0] r, input logic [151:0] h,
                         input logic [127:0] nz, output logic [127:0] key,
                         output logic anybad);
    logic [127:0] rn = r ^ nz;
    logic [6:0] f;  logic bd;
    anybad = 1'b0;  key = '0;
    for (int k = 0; k < 19; k++) begin
      m_dec(m_seg(rn, k), h[8 * k +: 8], f, bd);
      if (bd) anybad = 1'b1;
      for (int b = 0; b < 7; b++) if (7 * k + b < 128) key[7 * k + b] = f[b];
    end
  endtask

  function automatic logic [127:0] m_noise(input int nerr, input int seed);
    logic [127:0] nz = '0;
    int avail, n;
    for (int k = 0; k < 19; k++) begin
      avail = (k < 18) ? 7 : 2;
      n = (nerr < avail) ? nerr : avail;
      for (int m = 0; m < n; m++) nz[7 * k + ((seed + k + 3 * m) % avail)] = 1'b1;
    end
    return nz;
  endfunction

  // ---- bench utilities ----
  task automatic chk(input string tag, input logic [151:0] act, input logic [151:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic en, input logic bh, input logic srng,
                       input logic [15:0] c, input logic [15:0] r, input logic [2:0] h,
                       input logic [151:0] hp, input logic [127:0] nz);
    int n = 0;
    @(negedge clk);
    op_enroll = en;  op_by_handle = bh;  chal_from_rng = srng;
    chal_in = c;  rng_in = r;  handle_in = h;  helper_in = hp;  noise_in = nz;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R9 done reached", {151'b0, done}, 152'd1);
  endtask

  // stimulus table: chal | rng | sel | handle | nerr | 0 | seed
  localparam logic [63:0] VEC [6] = '{
    64'h1234_0000_0000_0000,
    64'hBEEF_0000_0110_0002,
    64'h0000_5A5A_1220_0005,
    64'h0000_0000_0320_0001,
    64'hFFFF_0000_0410_0004,
    64'h8001_0000_0530_0000
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [127:0] resp, nz, ekey;
    logic [151:0] hlp;
    logic [15:0] c;
    logic bd;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 busy", {151'b0, busy}, 152'd0);
    chk("R10 done", {151'b0, done}, 152'd0);
    chk("R10 flags", {149'b0, key_valid, uncorr_err, handle_err}, 152'd0);
    chk("R10 key", {24'b0, key_out}, 152'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: table empty after reset
    do_op(1'b0, 1'b1, 1'b0, 16'h0, 16'h0, 3'd2, '0, '0);
    chk("R10 empty table", {150'b0, handle_err, key_valid}, 152'd2);

    for (int v = 0; v < 6; v++) begin
      c = VEC[v][31:28] != 0 ? VEC[v][47:32] : VEC[v][63:48];
      resp = m_resp(c);
      hlp = m_help(resp);
      do_op(1'b1, 1'b0, VEC[v][28], VEC[v][63:48], VEC[v][47:32], VEC[v][26:24], '0, '0);
      chk("R2 enroll response", {24'b0, key_out}, {24'b0, resp});
      chk("R1 helper", helper_out, hlp);
      chk("R8 chal_out", {136'b0, chal_out}, {136'b0, c});
      chk("R3 key_valid", {151'b0, key_valid}, 152'd1);
      nz = m_noise(int'(VEC[v][23:20]), int'(VEC[v][15:0]));
      m_recon(resp, hlp, nz, ekey, bd);
      do_op(1'b0, 1'b0, 1'b0, c, 16'h0, 3'd0, hlp, nz);
      if (!bd) chk("R4 corrected key", {24'b0, key_out}, {24'b0, ekey});
      chk("R4/R5 valid,uncorr", {150'b0, key_valid, uncorr_err}, {150'b0, !bd, bd});
      do_op(1'b0, 1'b1, 1'b0, 16'h0, 16'h0, VEC[v][26:24], '0, nz);
      if (!bd) chk("R6 key by handle", {24'b0, key_out}, {24'b0, ekey});
      chk("R6 chal by handle", {135'b0, key_valid, chal_out}, {135'b0, !bd, c});
    end

    // R3: enrollment under noise, then clean lookup converges to noisy response
    resp = m_resp(16'h7777);
    nz = m_noise(1, 3);
    do_op(1'b1, 1'b0, 1'b0, 16'h7777, 16'h0, 3'd6, '0, nz);
    chk("R3 noisy enroll key", {24'b0, key_out}, {24'b0, resp ^ nz});
    chk("R3 noisy enroll helper", helper_out, m_help(resp ^ nz));
    do_op(1'b0, 1'b1, 1'b0, 16'h0, 16'h0, 3'd6, '0, '0);
    chk("R6 lookup after noisy enroll", {24'b0, key_out}, {24'b0, resp ^ nz});

    // R5: an undecodable 3-bit pattern in segment 0 only
    resp = m_resp(16'h2468);
    hlp = m_help(resp);
    nz = '0;
    for (int p = 0; p < 128; p++) begin
      logic [6:0] f;  logic b2;
      if (nz == '0 && $countones(p[6:0]) == 3) begin
        m_dec(m_seg(resp, 0) ^ p[6:0], hlp[7:0], f, b2);
        if (b2) nz[6:0] = p[6:0];
      end
    end
    do_op(1'b0, 1'b0, 1'b0, 16'h2468, 16'h0, 3'd0, hlp, nz);
    chk("R5 sticky uncorr", {150'b0, uncorr_err, key_valid}, 152'd2);

    // R7: never-enrolled handle
    do_op(1'b0, 1'b1, 1'b0, 16'h0, 16'h0, 3'd7, '0, '0);
    chk("R7 handle_err", {150'b0, handle_err, key_valid}, 152'd2);
    chk("R7 no key", {24'b0, key_out}, 152'd0);

    // R9: clearing at start, busy, start ignored while busy, done one cycle
    do_op(1'b1, 1'b0, 1'b0, 16'h4321, 16'h0, 3'd5, '0, '0);
    @(negedge clk);
    chal_in = 16'h1111;  op_enroll = 1'b1;  op_by_handle = 1'b0;  chal_from_rng = 1'b0;
    noise_in = '0;  start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy and cleared", {23'b0, busy, key_valid, key_out}, {23'b0, 1'b1, 1'b0, 128'b0});
    repeat (4) @(negedge clk);
    chal_in = 16'h2222;  start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 40 && !done; n++) @(negedge clk);
    chk("R9 ignored start chal", {136'b0, chal_out}, {136'b0, 16'h1111});
    chk("R9 ignored start key", {24'b0, key_out}, {24'b0, m_resp(16'h1111)});
    @(negedge clk);
    chk("R9 done single cycle", {150'b0, done, busy}, 152'd0);
    // R9: a clean operation after an uncorrectable one clears the flag
    do_op(1'b0, 1'b1, 1'b0, 16'h0, 16'h0, 3'd0, '0, '0);
    chk("R9 flag cleared", {150'b0, uncorr_err, key_valid}, 152'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule